// File: doc/BRIEF.md
# Differential Character Display Refresher

This block keeps a 2-line by 16-character text screen up to date while sending as few bus transfers as possible. It holds two 32-byte character stores. The target store holds the text that should be on the screen. The shadow store holds the text the screen is known to show. A byte-stream loader fills the target store. It starts at a chosen position and stops at the first byte that cannot be printed.

When asked to refresh, the block steps through every screen position in screen order. At each position it compares the target byte with the shadow byte. Where they differ, it asks a downstream display bus engine for two transfers: first a cursor-set instruction for that position, then a data write of the character. The shadow store then takes the new byte. Positions that match produce no traffic. The cursor code runs across the first line, then jumps to the base code of the second line. A one-cycle completion pulse marks the end of the walk. A refresh request that arrives during a walk is remembered and starts a fresh walk straight after.

Top module: `text_diff_refresher`

## Requirements
- R1: After reset `reqValid` and `done` are low. The shadow store holds 0xFF and the target store holds 0x20 (space), so the first refresh sends all 32 positions.
- R2: A high `loadStart` sets the write position to `loadAt` and arms the loader; a `loadByte` presented in that same cycle is ignored. Each accepted printable byte is stored at the write position, and the position then moves up by one.
- R3: The loader stores only bytes in 0x20..0x7F. A byte with bit 7 set, or below 0x20 (a zero terminator included), is not stored and disarms the loader. Later bytes are ignored until the next `loadStart`.
- R4: After a byte is stored at position 31, the loader disarms and stores nothing more.
- R5: The walk visits positions 0..31 in order. Position i (i<16) has cursor code 0x80+i. Position i (i>=16) has cursor code 0xC0+(i-16). The code jumps from 0x8F to 0xC0, and the walk ends when the code would reach 0xD0.
- R6: A position whose target byte equals its shadow byte produces no bus request.
- R7: For a differing position, the block first issues a request with `reqIsData`=0 carrying the cursor code, then a request with `reqIsData`=1 carrying the character. Each request, with its flag and byte, holds steady until `reqAck` is seen high at a clock edge.
- R8: After a position's data write is acknowledged, the shadow store holds the written byte. An immediate second refresh with no new load sends nothing.
- R9: `done` is high for exactly one cycle at the end of each walk. When no position differs, `done` rises after the 32nd clock edge following the edge that accepted the refresh request.
- R10: A refresh request made during a walk is held. A new walk starts right after the running walk's `done` cycle, giving a second `done` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStart | input | 1 | Arm the loader and set the write position |
| loadAt | input | 5 | Starting write position for the loader |
| loadValid | input | 1 | `loadByte` carries a stream byte this cycle |
| loadByte | input | 8 | Incoming character stream byte |
| refreshReq | input | 1 | Request a refresh walk |
| reqValid | output | 1 | Request to the display bus engine is pending |
| reqIsData | output | 1 | 0 = cursor instruction, 1 = character data |
| reqByte | output | 8 | Instruction code or character byte |
| reqAck | input | 1 | Bus engine accepts the pending request |
| done | output | 1 | One-cycle pulse when a walk finishes |

## Verification
A loaded byte lands in the target store at the clock edge that samples it. A refresh request starts the walk at the edge that samples it. With nothing to send, `done` is due exactly 32 edges later. The bench checks that cycle and the cycle before it at the falling edge. Bus requests appear one cycle after the comparison at their position and wait for an acknowledge, which the bench's responder gives after a random delay of zero to two cycles. For that reason the transfer list is checked in order and by content once `done` is seen, not at fixed cycles. The expected transfers come from the bench's own models of the loader and the two stores.

// File: rtl/txr_pkg.sv
package txr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_ADDR,
    ST_DATA,
    ST_DONE
  } walkState_t;

  // Strobes from the walk control to the buffer datapath
  typedef struct packed {
    logic walkInit;   // restart cursor and index at the first position
    logic latchChar;  // capture the target byte at the current index
    logic advance;    // step to the next position
    logic commit;     // copy the captured byte into the shadow store
    logic sendData;   // request byte is the character, not the cursor code
  } walkStrobe_t;

endpackage

// File: rtl/txr_loader.sv
module txr_loader #(
  parameter int DEPTH = 32,
  parameter int IDXW  = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadStart,
  input  logic [IDXW-1:0] loadAt,
  input  logic            loadValid,
  input  logic [7:0]      loadByte,
  output logic            wrEn,
  output logic [IDXW-1:0] wrIdx,
  output logic [7:0]      wrByte
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(DEPTH - 1);

  logic            armed;
  logic [IDXW-1:0] wrPtr;
  logic            printable;

  assign printable = !loadByte[7] && (loadByte >= 8'h20);
  assign wrEn      = armed && loadValid && !loadStart && printable;
  assign wrIdx     = wrPtr;
  assign wrByte    = loadByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
      wrPtr <= '0;
    end else if (loadStart) begin
      armed <= 1'b1;
      wrPtr <= loadAt;
    end else if (armed && loadValid) begin
      if (printable) begin
        wrPtr <= wrPtr + IDXW'(1);
        if (wrPtr == LAST_IDX) armed <= 1'b0;
      end else begin
        armed <= 1'b0;
      end
    end
  end

  AST_LOAD_FILTER: assert property (@(posedge clk) disable iff (!rstN)
    loadValid && (loadByte[7] || loadByte < 8'h20) |-> !wrEn); // R3

  AST_LOAD_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> loadStart || !armed || (wrPtr == $past(wrPtr) + IDXW'(1))); // R2

  AST_LOAD_END_STOP: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && (wrIdx == LAST_IDX) |=> !armed || $past(loadStart)); // R4

endmodule

// File: rtl/txr_datapath.sv
module txr_datapath
  import txr_pkg::*;
#(
  parameter int         LINE_LEN   = 16,
  parameter int         DEPTH      = 32,
  parameter int         IDXW       = 5,
  parameter logic [7:0] LINE0_BASE = 8'h80,
  parameter logic [7:0] LINE1_BASE = 8'hC0,
  parameter logic [7:0] FILL_BYTE  = 8'hFF,
  parameter logic [7:0] BLANK_BYTE = 8'h20
) (
  input  logic            clk,
  input  logic            rstN,
  input  walkStrobe_t     strobe,
  input  logic            wrEn,
  input  logic [IDXW-1:0] wrIdx,
  input  logic [7:0]      wrByte,
  output logic            differs,
  output logic            walkLast,
  output logic [7:0]      reqByte
);

  localparam logic [7:0] LINE0_END = 8'(LINE0_BASE + LINE_LEN);
  localparam logic [7:0] LINE1_END = 8'(LINE1_BASE + LINE_LEN);

  logic [7:0]      nextBuf [DEPTH];
  logic [7:0]      curBuf  [DEPTH];
  logic [IDXW-1:0] idx;
  logic [7:0]      cursor;
  logic [7:0]      heldChar;
  logic [7:0]      cursorInc;
  logic [7:0]      cursorNext;

  always_comb begin
    cursorInc  = cursor + 8'd1;
    cursorNext = (cursorInc == LINE0_END) ? LINE1_BASE : cursorInc;
  end

  assign walkLast = (cursorNext == LINE1_END);
  assign differs  = (nextBuf[idx] != curBuf[idx]);
  assign reqByte  = strobe.sendData ? heldChar : cursor;

  // Target store: written only by the loader
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) nextBuf[i] <= BLANK_BYTE;
    end else if (wrEn) begin
      nextBuf[wrIdx] <= wrByte;
    end
  end

  // Shadow store: what the screen shows
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) curBuf[i] <= FILL_BYTE;
    end else if (strobe.commit) begin
      curBuf[idx] <= heldChar;
    end
  end

  // Walk position and captured character
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cursor   <= LINE0_BASE;
      idx      <= '0;
      heldChar <= BLANK_BYTE;
    end else begin
      if (strobe.walkInit) begin
        cursor <= LINE0_BASE;
        idx    <= '0;
      end else if (strobe.advance) begin
        cursor <= cursorNext;
        idx    <= idx + IDXW'(1);
      end
      if (strobe.latchChar) heldChar <= nextBuf[idx];
    end
  end

  AST_CURSOR_IN_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (cursor >= LINE0_BASE && cursor < LINE0_END) ||
    (cursor >= LINE1_BASE && cursor <= LINE1_END)); // R5

  AST_LINE0_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (cursor < LINE0_END) |-> (idx == IDXW'(cursor - LINE0_BASE))); // R5

  AST_LINE1_INDEX: assert property (@(posedge clk) disable iff (!rstN)
    (cursor >= LINE1_BASE && cursor < LINE1_END) |->
      (idx == IDXW'(32'(cursor - LINE1_BASE) + LINE_LEN))); // R5

  AST_DIFF_ONLY_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latchChar |-> differs); // R6

endmodule

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        refreshReq,
  input  logic        reqAck,
  input  logic        differs,
  input  logic        walkLast,
  output walkStrobe_t strobe,
  output logic        reqValid,
  output logic        reqIsData,
  output logic        done
);

  walkState_t state;
  walkState_t stateNx;
  logic       pending;
  logic       startWalk;

  assign startWalk = refreshReq || pending;

  always_comb begin
    stateNx   = state;
    strobe    = '0;
    reqValid  = 1'b0;
    reqIsData = 1'b0;
    done      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startWalk) begin
          strobe.walkInit = 1'b1;
          stateNx         = ST_CMP;
        end
      end
      ST_CMP: begin
        if (differs) begin
          strobe.latchChar = 1'b1;
          stateNx          = ST_ADDR;
        end else begin
          strobe.advance = 1'b1;
          if (walkLast) stateNx = ST_DONE;
        end
      end
      ST_ADDR: begin
        reqValid = 1'b1;
        if (reqAck) stateNx = ST_DATA;
      end
      ST_DATA: begin
        reqValid        = 1'b1;
        reqIsData       = 1'b1;
        strobe.sendData = 1'b1;
        if (reqAck) begin
          strobe.commit  = 1'b1;
          strobe.advance = 1'b1;
          stateNx        = walkLast ? ST_DONE : ST_CMP;
        end
      end
      ST_DONE: begin
        done = 1'b1;
        if (startWalk) begin
          strobe.walkInit = 1'b1;
          stateNx         = ST_CMP;
        end else begin
          stateNx = ST_IDLE;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pending <= 1'b0;
    end else begin
      state <= stateNx;
      if (strobe.walkInit)  pending <= 1'b0;
      else if (refreshReq)  pending <= 1'b1;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqIsData)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_PENDING_SERVED: assert property (@(posedge clk) disable iff (!rstN)
    done && pending |=> !pending && state == ST_CMP); // R10

endmodule

// File: rtl/text_diff_refresher.sv
module text_diff_refresher
  import txr_pkg::*;
#(
  parameter int         LINE_LEN   = 16,
  parameter logic [7:0] LINE0_BASE = 8'h80,
  parameter logic [7:0] LINE1_BASE = 8'hC0,
  parameter logic [7:0] FILL_BYTE  = 8'hFF,
  parameter logic [7:0] BLANK_BYTE = 8'h20,
  localparam int        DEPTH      = 2 * LINE_LEN,
  localparam int        IDXW       = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            loadStart,
  input  logic [IDXW-1:0] loadAt,
  input  logic            loadValid,
  input  logic [7:0]      loadByte,
  input  logic            refreshReq,
  output logic            reqValid,
  output logic            reqIsData,
  output logic [7:0]      reqByte,
  input  logic            reqAck,
  output logic            done
);

  walkStrobe_t     strobe;
  logic            differs;
  logic            walkLast;
  logic            wrEn;
  logic [IDXW-1:0] wrIdx;
  logic [7:0]      wrByte;

  txr_loader #(.DEPTH(DEPTH), .IDXW(IDXW)) u_loader (
    .clk       (clk),
    .rstN      (rstN),
    .loadStart (loadStart),
    .loadAt    (loadAt),
    .loadValid (loadValid),
    .loadByte  (loadByte),
    .wrEn      (wrEn),
    .wrIdx     (wrIdx),
    .wrByte    (wrByte)
  );

  txr_datapath #(
    .LINE_LEN   (LINE_LEN),
    .DEPTH      (DEPTH),
    .IDXW       (IDXW),
    .LINE0_BASE (LINE0_BASE),
    .LINE1_BASE (LINE1_BASE),
    .FILL_BYTE  (FILL_BYTE),
    .BLANK_BYTE (BLANK_BYTE)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrByte   (wrByte),
    .differs  (differs),
    .walkLast (walkLast),
    .reqByte  (reqByte)
  );

  txr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refreshReq (refreshReq),
    .reqAck     (reqAck),
    .differs    (differs),
    .walkLast   (walkLast),
    .strobe     (strobe),
    .reqValid   (reqValid),
    .reqIsData  (reqIsData),
    .done       (done)
  );

  AST_BYTE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> $stable(reqByte)); // R7

  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqIsData && !$past(reqValid && reqIsData) |->
      $past(reqValid && !reqIsData && reqAck)); // R7

  AST_DATA_PRINTABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqIsData |-> !reqByte[7] && reqByte >= 8'h20); // R3

  AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqValid); // R9

endmodule

// File: tb/text_diff_refresher_bench.sv
module text_diff_refresher_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 32;
  localparam int LOG_MAX    = 256;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadStart = 1'b0;
  logic [4:0] loadAt = '0;
  logic       loadValid = 1'b0;
  logic [7:0] loadByte = '0;
  logic       refreshReq = 1'b0;
  logic       reqValid;
  logic       reqIsData;
  logic [7:0] reqByte;
  logic       reqAck = 1'b0;
  logic       done;

  int nChecks = 0;
  int nFail   = 0;

  logic [7:0] nextM [DEPTH];
  logic [7:0] curM  [DEPTH];
  logic [7:0] stim  [64];

  logic [7:0] logByte [LOG_MAX];
  logic       logData [LOG_MAX];
  int         logCount = 0;
  int         ackWait  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  text_diff_refresher u_text_diff_refresher (
    .clk(clk), .rstN(rstN), .loadStart(loadStart), .loadAt(loadAt),
    .loadValid(loadValid), .loadByte(loadByte), .refreshReq(refreshReq),
    .reqValid(reqValid), .reqIsData(reqIsData), .reqByte(reqByte),
    .reqAck(reqAck), .done(done)
  );

  // Bus engine model: acknowledges after 0..2 idle cycles and logs each transfer
  initial begin
    forever begin
      @(negedge clk);
      if (reqAck) begin
        reqAck = 1'b0;
      end else if (reqValid) begin
        if (ackWait == 0) begin
          reqAck = 1'b1;
          if (logCount < LOG_MAX) begin
            logByte[logCount] = reqByte;
            logData[logCount] = reqIsData;
          end
          logCount++;
          ackWait = $urandom % 3;
        end else begin
          ackWait--;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] cursorCode(input int pos);
    return (pos < 16) ? 8'(8'h80 + pos) : 8'(8'hC0 + pos - 16);
  endfunction

  function automatic bit isPrintable(input logic [7:0] b);
    return !b[7] && b >= 8'h20;
  endfunction

  task automatic waitDone(input string req);
    int guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!done && guard < 3000);
    check(done, req, "done never seen", 0, 1);
  endtask

  // Compare logged transfers with the model and bring the shadow model up to date
  task automatic compareWalk(input string req);
    int n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (nextM[i] != curM[i]) begin
        if (n + 1 < logCount && n + 1 < LOG_MAX) begin
          check(logData[n] == 1'b0, "R7", "flag of cursor transfer", logData[n], 0);
          check(logByte[n] == cursorCode(i), "R5", "cursor code", logByte[n], cursorCode(i));
          check(logData[n+1] == 1'b1, "R7", "flag of data transfer", logData[n+1], 1);
          check(logByte[n+1] == nextM[i], req, "character byte", logByte[n+1], nextM[i]);
        end
        n += 2;
        curM[i] = nextM[i];
      end
    end
    check(logCount == n, "R6", "transfer count", logCount, n);
  endtask

  task automatic refresh(input string req);
    logCount = 0;
    @(negedge clk); refreshReq = 1'b1;
    @(negedge clk); refreshReq = 1'b0;
    waitDone(req);
    compareWalk(req);
  endtask

  task automatic loadStim(input int at, input int n);
    int  ptr = at;
    bit  on  = 1'b1;
    @(negedge clk); loadStart = 1'b1; loadAt = 5'(at);
    loadValid = 1'b1; loadByte = 8'h41;   // same-cycle byte must be ignored (R2)
    @(negedge clk); loadStart = 1'b0;
    for (int k = 0; k < n; k++) begin
      if ($urandom % 4 == 0) begin
        loadValid = 1'b0;
        @(negedge clk);
      end
      loadValid = 1'b1;
      loadByte  = stim[k];
      if (on) begin
        if (isPrintable(stim[k])) begin
          nextM[ptr] = stim[k];
          ptr++;
          if (ptr == DEPTH) on = 1'b0;
        end else begin
          on = 1'b0;
        end
      end
      @(negedge clk);
    end
    loadValid = 1'b0;
  endtask

  function automatic logic [7:0] randByte();
    int r = $urandom % 24;
    if (r == 0) return 8'($urandom % 32);
    if (r == 1) return 8'h80 | 8'($urandom);
    return 8'(8'h20 + ($urandom % 95));
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    int seedInit = $urandom(32'd4711);
    if (seedInit < 0) $display("seed");
    for (int i = 0; i < DEPTH; i++) begin
      nextM[i] = 8'h20;
      curM[i]  = 8'hFF;
    end
    repeat (3) @(negedge clk);
    check(!reqValid, "R1", "reqValid in reset", reqValid, 0);
    check(!done, "R1", "done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!reqValid && !done, "R1", "outputs idle after reset", {reqValid, done}, 0);

    // R1/R5/R7: first refresh sends every position
    refresh("R1");

    // R8/R9: nothing changed, exact completion cycle
    logCount = 0;
    @(negedge clk); refreshReq = 1'b1;
    @(negedge clk); refreshReq = 1'b0;
    repeat (31) @(negedge clk);
    check(!done, "R9", "done early", done, 0);
    @(negedge clk);
    check(done, "R9", "done on 32nd edge", done, 1);
    @(negedge clk);
    check(!done, "R9", "done one cycle", done, 0);
    check(logCount == 0, "R8", "transfers after unchanged refresh", logCount, 0);

    // R2/R3: zero terminator stops the loader
    stim[0] = "H"; stim[1] = "e"; stim[2] = "l"; stim[3] = "l"; stim[4] = "o";
    stim[5] = 8'h00; stim[6] = "Z"; stim[7] = "Z";
    loadStim(3, 8);
    refresh("R2");

    // R3: byte with top bit set stops the loader across the line boundary
    stim[0] = "a"; stim[1] = "b"; stim[2] = 8'hC1; stim[3] = "q";
    loadStim(15, 4);
    refresh("R3");

    // R4: loader stops after the last position
    stim[0] = "x"; stim[1] = "y"; stim[2] = "w"; stim[3] = "v";
    loadStim(30, 4);
    refresh("R4");

    // Random loads and refreshes
    for (int it = 0; it < 20; it++) begin
      int len = 1 + ($urandom % 40);
      for (int k = 0; k < len; k++) stim[k] = randByte();
      loadStim($urandom % DEPTH, len);
      refresh("R7");
    end

    // R10: a second request during a walk is held and served
    for (int k = 0; k < 32; k++) stim[k] = 8'(8'h30 + (k % 40));
    loadStim(0, 32);
    logCount = 0;
    @(negedge clk); refreshReq = 1'b1;
    @(negedge clk); refreshReq = 1'b0;
    repeat (5) @(negedge clk);
    refreshReq = 1'b1;
    @(negedge clk); refreshReq = 1'b0;
    waitDone("R10");
    compareWalk("R10");
    logCount = 0;
    waitDone("R10");
    check(logCount == 0, "R10", "held walk transfers", logCount, 0);
    @(negedge clk);
    check(!done, "R10", "done after held walk", done, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule